// File: doc/BRIEF.md
# Change-of-State Interrupt Controller

This block watches 32 input lines, 24 isolated inputs and 8 logic-level lines, after passing them through a two-stage synchroniser. The lines are split into four banks of eight. Bank 0 holds isolated inputs 0-7, bank 1 holds 8-15, bank 2 holds 16-23 and bank 3 holds the logic-level lines. Each bank has its own enable bit for rising edges and its own enable bit for falling edges. When an enabled edge is seen on a line, the status bit for that line is set and stays set. The interrupt output is high whenever any status bit is set.

Software reaches the block through a simple register bus. A request is presented for one cycle, and read data comes back on the next cycle. Each bank's status is a byte register, and the four status bytes sit at consecutive addresses. The same four bytes can also be read or cleared together in one word access. Writing to a status register clears only the bits written as 1, so an edge that arrives between the read and the clear is not lost. The edge-enable byte is another register on the same bus. An interrupt handler reads the status word, treats an all-zero value as "not this device", and writes back the value it read.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset, every status bit is 0, the enable register is 0, `irq_o` is 0 and `bus_rvalid_o` is 0.
- R2: If enable bit b (b = 0..3) is set, a 0-to-1 change on a line of bank b sets that line's status bit on the third rising clock edge after the change. Line i of bank b maps to status bit 8*b+i.
- R3: If enable bit b+4 is set, a 1-to-0 change on a line of bank b sets that line's status bit, with the same latency as R2.
- R4: An edge whose enable bit is 0 sets no status bit. The enable bits of one bank have no effect on any other bank.
- R5: A status bit stays set after its input line returns to its earlier level, and stays set until software clears it.
- R6: `irq_o` is 1 exactly when at least one status bit is 1.
- R7: A byte write (`bus_word_i`=0) to address n (n = 0..3) clears the bits of bank n that are written as 1 in `bus_wdata_i[7:0]`. All other status bits are left unchanged.
- R8: A word access (`bus_word_i`=1) to any address from 0 to 3 covers all four banks, with bank n in data bits 8n+7..8n. A word read returns all status bits. A word write clears every bit written as 1.
- R9: If an edge sets a status bit in the same cycle that a write clears it, the bit stays set.
- R10: Clearing the enable bits of a bank stops new detections in that bank but leaves its pending status bits set.
- R11: The enable register is at address 4, and a write to it takes effect on the next edge. A read request returns its data on `bus_rdata_o` with `bus_rvalid_o` high one cycle after the request. Byte reads of a status register or of the enable register return zero in the unused upper bits.
- R12: A write to any address above 4 changes nothing. A read from such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iso_i | input | 24 | Isolated input lines, asynchronous (banks 0-2) |
| lvl_i | input | 8 | Logic-level input lines, asynchronous (bank 3) |
| bus_req_i | input | 1 | Bus request, valid for one cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_word_i | input | 1 | 1 = word access over all status banks, 0 = byte access |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 32 | Write data (a byte access uses bits 7:0) |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| irq_o | output | 1 | Interrupt, high while any status bit is set |

## Verification
An input change made at a falling clock edge reaches its status bit and `irq_o` on the third rising edge. That edge is two synchroniser stages plus the sticky register. A register request is answered one edge later, and an enable or clear write acts on the edge that samples it. The bench drives all stimulus on falling edges. Its reference model keeps a queue of the input values sampled at each rising edge and judges each edge from the entries two and three samples back. The bench compares `irq_o`, `bus_rvalid_o` and the read data with this model on every falling edge. Directed checks probe the exact cycle in which an edge lands, and they line up a clear with that edge for the same-cycle case.

// File: rtl/cos_irq_pkg.sv
package cos_irq_pkg;
  typedef enum logic {
    ACC_BYTE = 1'b0,
    ACC_WORD = 1'b1
  } acc_size_e;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/cos_edge_det.sv
module cos_edge_det #(
  parameter int unsigned BANKS  = 4,
  parameter int unsigned BANK_W = 8,
  localparam int unsigned LINES = BANKS * BANK_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] line_i,
  input  logic [BANKS-1:0] rise_en_i,
  input  logic [BANKS-1:0] fall_en_i,
  output logic [LINES-1:0] hit_o
);
  logic [LINES-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= line_i;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [BANK_W-1:0] cur, old;
    assign cur = line_i[b*BANK_W +: BANK_W];
    assign old = prev_q[b*BANK_W +: BANK_W];
    assign hit_o[b*BANK_W +: BANK_W] = ({BANK_W{rise_en_i[b]}} &  cur & ~old)
                                     | ({BANK_W{fall_en_i[b]}} & ~cur &  old);
  end
endmodule

// File: rtl/cos_status.sv
module cos_status #(
  parameter int unsigned LINES = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] hit_i,
  input  logic [LINES-1:0] clr_i,
  output logic [LINES-1:0] stat_o
);
  logic [LINES-1:0] stat_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_i) | hit_i;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/cos_regif.sv
module cos_regif
  import cos_irq_pkg::*;
#(
  parameter int unsigned BANKS  = 4,
  parameter int unsigned BANK_W = 8,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned LINES = BANKS * BANK_W,
  localparam int unsigned ENA_W = 2 * BANKS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              word_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LINES-1:0]  wdata_i,
  input  logic [LINES-1:0]  stat_i,
  output logic [LINES-1:0]  clr_o,
  output logic [BANKS-1:0]  rise_en_o,
  output logic [BANKS-1:0]  fall_en_o,
  output logic [LINES-1:0]  rdata_o,
  output logic              rvalid_o
);
  localparam logic [ADDR_W-1:0] EnaAddr = ADDR_W'(BANKS);

  acc_size_e        acc;
  logic             wr, rd, stat_rng, word_stat;
  logic [ENA_W-1:0] ena_q;
  logic [LINES-1:0] rd_nxt, rdata_q;
  logic             rvalid_q;

  assign acc       = acc_size_e'(word_i);
  assign wr        = req_i & we_i;
  assign rd        = req_i & ~we_i;
  assign stat_rng  = addr_i < EnaAddr;
  assign word_stat = stat_rng && (acc == ACC_WORD);

  for (genvar b = 0; b < BANKS; b++) begin : g_clr
    logic byte_hit;
    assign byte_hit = (acc == ACC_BYTE) && (addr_i == ADDR_W'(b));
    assign clr_o[b*BANK_W +: BANK_W] =
        !wr       ? '0 :
        word_stat ? wdata_i[b*BANK_W +: BANK_W] :
        byte_hit  ? wdata_i[BANK_W-1:0] : '0;
  end

  always_comb begin
    rd_nxt = '0;
    if (word_stat) begin
      rd_nxt = stat_i;
    end else if (stat_rng) begin
      for (int b = 0; b < BANKS; b++)
        if (addr_i == ADDR_W'(b)) rd_nxt[BANK_W-1:0] = stat_i[b*BANK_W +: BANK_W];
    end else if (addr_i == EnaAddr) begin
      rd_nxt[ENA_W-1:0] = ena_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ena_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (wr && addr_i == EnaAddr) ena_q <= wdata_i[ENA_W-1:0];
      rvalid_q <= rd;
      if (rd) rdata_q <= rd_nxt;
    end
  end

  assign rise_en_o = ena_q[BANKS-1:0];
  assign fall_en_o = ena_q[ENA_W-1:BANKS];
  assign rdata_o   = rdata_q;
  assign rvalid_o  = rvalid_q;
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl #(
  parameter int unsigned BANKS  = 4,
  parameter int unsigned BANK_W = 8,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned LINES = BANKS * BANK_W,
  localparam int unsigned ISO_W = (BANKS - 1) * BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ISO_W-1:0]  iso_i,
  input  logic [BANK_W-1:0] lvl_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic              bus_word_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [LINES-1:0]  bus_wdata_i,
  output logic [LINES-1:0]  bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic              irq_o
);
  logic [LINES-1:0] line_sync, hit, clr, stat_q;
  logic [BANKS-1:0] rise_en, fall_en;

  cos_sync #(.WIDTH(LINES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({lvl_i, iso_i}),
    .q_o   (line_sync)
  );

  cos_edge_det #(.BANKS(BANKS), .BANK_W(BANK_W)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_i   (line_sync),
    .rise_en_i(rise_en),
    .fall_en_i(fall_en),
    .hit_o    (hit)
  );

  cos_status #(.LINES(LINES)) u_stat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hit_i (hit),
    .clr_i (clr),
    .stat_o(stat_q)
  );

  cos_regif #(.BANKS(BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_regif (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (bus_req_i),
    .we_i     (bus_we_i),
    .word_i   (bus_word_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .stat_i   (stat_q),
    .clr_o    (clr),
    .rise_en_o(rise_en),
    .fall_en_o(fall_en),
    .rdata_o  (bus_rdata_o),
    .rvalid_o (bus_rvalid_o)
  );

  assign irq_o = |stat_q;
endmodule

// File: rtl/cos_irq_ctrl_chk.sv
module cos_irq_ctrl_chk #(
  parameter int unsigned BANKS  = 4,
  parameter int unsigned BANK_W = 8,
  localparam int unsigned LINES = BANKS * BANK_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_i,
  input logic             req_i,
  input logic             we_i,
  input logic             rvalid_i,
  input logic [LINES-1:0] stat_i,
  input logic [LINES-1:0] hit_i,
  input logic [BANKS-1:0] rise_en_i,
  input logic [BANKS-1:0] fall_en_i
);
  AST_SET_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(stat_i & ~$past(stat_i))) |-> $past(|hit_i)); // R2

  AST_CLR_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(stat_i) & ~stat_i)) |-> $past(req_i && we_i)); // R7

  AST_EDGE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(hit_i) & ~stat_i) == '0); // R9

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> $past(|hit_i)); // R6

  AST_RVALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_i |-> $past(req_i && !we_i)); // R11

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    AST_DISABLED_BANK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(!rise_en_i[b] && !fall_en_i[b]) |->
      ((stat_i[b*BANK_W +: BANK_W] & ~$past(stat_i[b*BANK_W +: BANK_W])) == '0)); // R4
  end
endmodule

bind cos_irq_ctrl cos_irq_ctrl_chk #(.BANKS(BANKS), .BANK_W(BANK_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_i    (irq_o),
  .req_i    (bus_req_i),
  .we_i     (bus_we_i),
  .rvalid_i (bus_rvalid_o),
  .stat_i   (stat_q),
  .hit_i    (hit),
  .rise_en_i(rise_en),
  .fall_en_i(fall_en)
);

// File: tb/cos_irq_ctrl_test.sv
`timescale 1ns/100ps
module cos_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] iso = '0;
  logic [7:0]  lvl = '0;
  logic        req = 1'b0, we = 1'b0, word = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, irq;

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  cos_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .iso_i(iso), .lvl_i(lvl),
    .bus_req_i(req), .bus_we_i(we), .bus_word_i(word), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_rvalid_o(rvalid), .irq_o(irq)
  );

  // reference model
  logic [31:0] hist[$];
  logic [31:0] m_stat = '0;
  logic [7:0]  m_ena = '0;
  logic [31:0] m_rd = '0;
  logic        m_rv = 1'b0;

  function automatic logic [31:0] m_read(logic [3:0] a, logic w);
    if (a < 4 && w) return m_stat;
    if (a < 4)      return {24'h0, m_stat[a*8 +: 8]};
    if (a == 4)     return {24'h0, m_ena};
    return '0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{32'h0, 32'h0, 32'h0, 32'h0};
      m_stat = '0; m_ena = '0; m_rd = '0; m_rv = 1'b0;
    end else begin
      logic [31:0] cur, old, hits, clr;
      hist.push_back({lvl, iso});
      while (hist.size() > 4) void'(hist.pop_front());
      cur = hist[1];
      old = hist[0];
      hits = '0;
      for (int i = 0; i < 32; i++) begin
        if (m_ena[i/8] && cur[i] && !old[i])     hits[i] = 1'b1;
        if (m_ena[i/8 + 4] && !cur[i] && old[i]) hits[i] = 1'b1;
      end
      clr = '0;
      if (req && we && addr < 4) begin
        if (word) clr = wdata;
        else      clr[addr*8 +: 8] = wdata[7:0];
      end
      m_rv = req && !we;
      if (req && !we) m_rd = m_read(addr, word);
      m_stat = (m_stat & ~clr) | hits;
      if (req && we && addr == 4) m_ena = wdata[7:0];
    end
  end

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6 irq", {31'h0, irq}, {31'h0, m_stat != 0});
      check("R11 rvalid", {31'h0, rvalid}, {31'h0, m_rv});
      if (m_rv) check({tag, " rdata model"}, rdata, m_rd);
    end
  end

  task automatic bus_wr(logic [3:0] a, logic w, logic [31:0] d);
    req = 1'b1; we = 1'b1; word = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd_chk(logic [3:0] a, logic w, logic [31:0] exp, string t);
    req = 1'b1; we = 1'b0; word = w; addr = a;
    @(negedge clk);
    req = 1'b0;
    check(t, rdata, exp);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 rvalid", {31'h0, rvalid}, 32'h0);
    bus_rd_chk(4'h0, 1'b1, 32'h0, "R1 status");
    bus_rd_chk(4'h4, 1'b0, 32'h0, "R1 enable");

    tag = "R11";
    bus_wr(4'h4, 1'b0, 32'h0F);
    bus_rd_chk(4'h4, 1'b0, 32'h0F, "R11 enable readback");

    // R2 exact latency
    tag = "R2";
    iso[3] = 1'b1;
    @(negedge clk); check("R2 edge1", {31'h0, irq}, 32'h0);
    @(negedge clk); check("R2 edge2", {31'h0, irq}, 32'h0);
    @(negedge clk); check("R2 edge3", {31'h0, irq}, 32'h1);
    bus_rd_chk(4'h0, 1'b0, 32'h08, "R2 bank0 byte");

    // R5 sticky, falling disabled
    tag = "R5";
    iso[3] = 1'b0;
    wait_cyc(4);
    bus_rd_chk(4'h0, 1'b1, 32'h08, "R5 sticky");

    // R7 byte clear
    tag = "R7";
    bus_wr(4'h1, 1'b0, 32'hFF);
    bus_wr(4'h0, 1'b0, 32'hF7);
    bus_rd_chk(4'h0, 1'b1, 32'h08, "R7 other bits kept");
    bus_wr(4'h0, 1'b0, 32'h08);
    bus_rd_chk(4'h0, 1'b1, 32'h0, "R7 cleared");
    check("R6 irq low", {31'h0, irq}, 32'h0);

    // R3 falling, R4 rising disabled
    tag = "R3";
    bus_wr(4'h4, 1'b0, 32'h80);
    lvl = 8'hFF;
    wait_cyc(4);
    bus_rd_chk(4'h0, 1'b1, 32'h0, "R4 rise disabled");
    lvl[5] = 1'b0;
    wait_cyc(4);
    bus_rd_chk(4'h0, 1'b1, 32'h2000_0000, "R3 falling bank3");
    bus_rd_chk(4'h3, 1'b0, 32'h20, "R3 byte bank3");

    // R4 other bank unaffected
    tag = "R4";
    iso[23:16] = 8'hFF;
    wait_cyc(4);
    iso[23:16] = 8'h00;
    wait_cyc(4);
    bus_rd_chk(4'h0, 1'b1, 32'h2000_0000, "R4 bank2 quiet");

    // R10 disabling keeps pending
    tag = "R10";
    bus_wr(4'h4, 1'b0, 32'h00);
    lvl[6] = 1'b0;
    wait_cyc(4);
    bus_rd_chk(4'h0, 1'b1, 32'h2000_0000, "R10 pending kept");
    check("R10 irq", {31'h0, irq}, 32'h1);

    // R8 word access
    tag = "R8";
    bus_wr(4'h4, 1'b0, 32'hFF);
    iso[9] = 1'b1; iso[17] = 1'b1;
    wait_cyc(4);
    bus_rd_chk(4'h2, 1'b1, 32'h2002_0200, "R8 word read");
    bus_wr(4'h0, 1'b1, 32'h0002_0000);
    bus_rd_chk(4'h0, 1'b1, 32'h2000_0200, "R8 word partial clear");
    bus_wr(4'h0, 1'b1, 32'hFFFF_FFFF);
    bus_rd_chk(4'h0, 1'b1, 32'h0, "R8 word full clear");

    // R9 edge and clear in the same cycle
    tag = "R9";
    iso[0] = 1'b1;
    wait_cyc(4);
    bus_rd_chk(4'h0, 1'b1, 32'h1, "R9 setup");
    iso[0] = 1'b0;
    wait_cyc(2);
    bus_wr(4'h0, 1'b1, 32'h1);
    bus_rd_chk(4'h0, 1'b1, 32'h1, "R9 edge wins");
    bus_wr(4'h0, 1'b1, 32'h1);
    bus_rd_chk(4'h0, 1'b1, 32'h0, "R9 later clear");

    // R12 unmapped addresses
    tag = "R12";
    iso[12] = 1'b1;
    wait_cyc(4);
    bus_wr(4'hF, 1'b0, 32'h00);
    bus_wr(4'h9, 1'b1, 32'hFFFF_FFFF);
    bus_rd_chk(4'h4, 1'b0, 32'hFF, "R12 enable untouched");
    bus_rd_chk(4'h9, 1'b0, 32'h0, "R12 read zero");
    bus_rd_chk(4'h0, 1'b1, 32'h0000_1000, "R12 status untouched");

    wait_cyc(2);
    finish_run();
  end
endmodule